// File: doc/BRIEF.md
# Trace Stream Frame Splitter

This block takes the byte stream that leaves a trace port where several trace sources share the wire through fixed 16-byte frames. It rebuilds each frame, works out which source owns every payload byte, and passes on only the bytes of the one source selected by `sel_id`. It also shows which source is active at the moment. The consumer on the output sees a plain byte stream from one source, one byte per `out_valid` pulse.

The last byte of each frame is a side byte. It supplies the low bit of every even-position byte, because the formatter reuses that bit as a marker: 1 means the byte is a source-ID change, 0 means it is data. As a result, the block can only interpret a frame once its final byte has arrived. It keeps a copy of each completed frame and walks that copy one position per cycle, while the next frame fills in behind it.

The block finds frame alignment in three ways:
- a four-byte sync word,
- a pause in the input,
- a number of bytes dropped after reset.

Top module: `trace_frame_splitter`

## Requirements
- R1: While reset is held and just after it, `out_valid` is 0, `out_byte` is 0 and `active_id` is 0.
- R2: After reset, the first `skip_bytes` accepted bytes are discarded and not framed. The byte that follows them is frame position 0.
- R3: A frame is 16 bytes at positions 0 to 15. Bit k of the byte at position 15 gives the true bit 0 of the byte at position 2k (k = 0..7). An even-position data byte is emitted as its bits 7:1 joined with that side bit.
- R4: An even-position byte with bit 0 = 1 is a source-ID byte. The ID is bits 7:1. The byte itself is never emitted. If its side bit is 0, the new ID applies from the next position onward. The ID never changes while no frame is being walked.
- R5: If the side bit of an ID byte is 1, the change is deferred. The next odd-position byte is still attributed to the old ID, and the new ID applies after that byte.
- R6: Odd positions 1 to 13 always carry data for the active ID, passed on unmodified.
- R7: A data byte is emitted only when the active ID equals `sel_id` and is not 0. ID 0 never produces output, even when `sel_id` is 0.
- R8: When the four most recently accepted bytes are FF, FF, FF, 7F in arrival order, the partial frame is discarded. The next byte is position 0.
- R9: A byte that arrives after at least `gap_cycles` idle cycles (cycles with `in_valid` low) starts a new frame at position 0. It also clears the sync history.
- R10: The emitted bytes of a frame appear in position order, one per cycle, as single-cycle `out_valid` pulses. All of them appear within 16 cycles after the side byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Raw trace port byte |
| sel_id | input | 7 | Source ID whose bytes are passed on |
| skip_bytes | input | SKIP_W | Bytes dropped after reset before framing |
| gap_cycles | input | GAP_W | Idle cycles that count as a pause (at least 1) |
| out_valid | output | 1 | Output byte strobe |
| out_byte | output | 8 | Data byte of the selected source |
| active_id | output | 7 | Source ID currently in force |

## Verification
The assertions assume the following about the inputs:
- `skip_bytes` changes only while reset is held.
- `gap_cycles` is at least 1.
- Input bytes arrive no faster than one per cycle, so a frame takes at least 16 cycles to fill while the previous one is walked.

The stimulus respects these assumptions:
- It changes `sel_id` and `skip_bytes` only between frames or under reset.
- It keeps `gap_cycles` at 4.
- It sends frame bytes back to back, with no sync word inside the payload.

The directed cases misalign the stream on purpose, using junk bytes, a partial frame or dropped bytes. They show that each alignment mechanism restores the same decoded output.

// File: rtl/trace_frame_splitter.sv
module trace_frame_splitter #(
  parameter int GAP_W  = 16,
  parameter int SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic [6:0]        sel_id,
  input  logic [SKIP_W-1:0] skip_bytes,
  input  logic [GAP_W-1:0]  gap_cycles,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic [6:0]        active_id
);
  localparam int NPAY = 15;
  localparam logic [3:0] LAST = 4'(NPAY);
  localparam logic [31:0] SYNC_WORD = 32'hFFFF_FF7F;

  logic [3:0]        fpos;
  logic [7:0]        fbuf [NPAY];
  logic [23:0]       hist;
  logic [SKIP_W-1:0] skip_cnt;
  logic [GAP_W-1:0]  idle;

  logic              walking;
  logic [3:0]        wpos;
  logic [7:0]        wbuf [NPAY];
  logic [7:0]        waux;
  logic [6:0]        cur_id, pend_id;
  logic              pend_v;

  wire skipping  = skip_cnt < skip_bytes;
  wire take      = in_valid && !skipping;
  wire gap_hit   = idle >= gap_cycles;
  wire [3:0]  pos_now  = gap_hit ? 4'd0 : fpos;
  wire [23:0] hist_now = gap_hit ? 24'd0 : hist;
  wire sync_hit  = {hist_now, in_byte} == SYNC_WORD;
  wire frame_end = take && !sync_hit && (pos_now == LAST);

  wire [7:0] wb    = wbuf[wpos];
  wire       wodd  = wpos[0];
  wire       abit  = waux[wpos[3:1]];
  wire       is_id = !wodd && wb[0];
  wire [7:0] wdata = wodd ? wb : {wb[7:1], abit};
  wire       emit  = walking && !is_id && (cur_id == sel_id) && (cur_id != 7'd0);

  assign active_id = cur_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fpos     <= '0;
      hist     <= '0;
      skip_cnt <= '0;
      idle     <= '0;
      for (int i = 0; i < NPAY; i++) fbuf[i] <= '0;
    end else begin
      if (in_valid) idle <= '0;
      else if (idle != '1) idle <= idle + 1'b1;
      if (in_valid && skipping) skip_cnt <= skip_cnt + 1'b1;
      if (take) begin
        hist <= {hist_now[15:0], in_byte};
        if (sync_hit) fpos <= '0;
        else begin
          fpos <= pos_now + 4'd1;
          if (pos_now != LAST) fbuf[pos_now] <= in_byte;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walking   <= 1'b0;
      wpos      <= '0;
      waux      <= '0;
      cur_id    <= '0;
      pend_id   <= '0;
      pend_v    <= 1'b0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      for (int i = 0; i < NPAY; i++) wbuf[i] <= '0;
    end else begin
      out_valid <= emit;
      if (emit) out_byte <= wdata;
      if (walking) begin
        if (is_id) begin
          if (abit) begin
            pend_id <= wb[7:1];
            pend_v  <= 1'b1;
          end else begin
            cur_id <= wb[7:1];
            pend_v <= 1'b0;
          end
        end else if (wodd && pend_v) begin
          cur_id <= pend_id;
          pend_v <= 1'b0;
        end
        wpos <= wpos + 4'd1;
        if (wpos == LAST - 4'd1) walking <= 1'b0;
      end
      if (frame_end) begin
        for (int i = 0; i < NPAY; i++) wbuf[i] <= fbuf[i];
        waux    <= in_byte;
        wpos    <= '0;
        walking <= 1'b1;
      end
    end
  end

  assert_skip_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    skipping |-> (fpos == 4'd0));
  assert_id_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !walking |=> $stable(cur_id));
  assert_defer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (walking && wodd && pend_v) |=> (cur_id == $past(pend_id)));
  assert_null_never_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(cur_id) != 7'd0));
  assert_sync_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sync_hit) |=> (fpos == 4'd0));
  assert_gap_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !skipping && idle >= gap_cycles) |=> (fpos == 4'd1));
  assert_walk_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> (wpos < LAST));
  assert_out_from_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(walking));
endmodule

// File: tb/sim_trace_frame_splitter.sv
module sim_trace_frame_splitter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic [6:0] sel_id = '0;
  logic [7:0] skip_bytes = '0;
  logic [15:0] gap_cycles = 16'd4;
  logic       out_valid;
  logic [7:0] out_byte;
  logic [6:0] active_id;

  int tests = 0;
  int fails = 0;
  logic [7:0] got [$];

  trace_frame_splitter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .sel_id(sel_id), .skip_bytes(skip_bytes), .gap_cycles(gap_cycles),
    .out_valid(out_valid), .out_byte(out_byte), .active_id(active_id)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && out_valid) got.push_back(out_byte);

  localparam logic [127:0] FR_A = 128'h0B11223344556677_8899AABBCCDDEEAA;
  localparam logic [111:0] EX_A = 112'h11233344556777_8899ABBBCCDDEF;

  localparam logic [127:0] VFRAME [4] = '{
    FR_A,
    128'h0B01130304050B07_08100112_14160B12,
    128'h0121222324252627_28292A2B2C2D2E00,
    128'h0731323334353637_38393A3B3C3D3E01
  };
  localparam logic [6:0]   VSEL [4] = '{7'd5, 7'd5, 7'd0, 7'd3};
  localparam int           VCNT [4] = '{14, 5, 0, 13};
  localparam logic [111:0] VEXP [4] = '{
    EX_A,
    {40'h0103070910, 72'h0},
    112'h0,
    {104'h32333435363738393A3B3C3D3E, 8'h0}
  };
  localparam logic [6:0]   VID  [4] = '{7'd5, 7'd5, 7'd0, 7'd3};
  localparam string        VTAG [4] = '{"R3 R6 aux restore", "R4 R5 R7 id switching",
                                        "R7 null id", "R5 deferred at pos0"};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
  endtask

  task automatic idle_n(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic put_sync();
    put_byte(8'hFF); put_byte(8'hFF); put_byte(8'hFF); put_byte(8'h7F);
  endtask

  task automatic put_frame(input logic [127:0] f);
    for (int i = 0; i < 16; i++) put_byte(f[127-8*i -: 8]);
  endtask

  // R10: everything must be out 16 cycles after the side byte; sample one later.
  task automatic expect_out(input int n, input logic [111:0] ex, input logic [6:0] id, input string tag);
    idle_n(17);
    check(got.size() == n, {tag, " R10 count"}, got.size(), n);
    for (int i = 0; i < n && i < got.size(); i++)
      check(got[i] == ex[111-8*i -: 8], {tag, " byte"}, got[i], ex[111-8*i -: 8]);
    check(active_id == id, {tag, " active_id"}, active_id, id);
    got.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    idle_n(3);
    rst_n = 1'b1;
    got.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(out_byte == 0, "R1 out_byte", out_byte, 0);
    check(active_id == 0, "R1 active_id", active_id, 0);

    for (int v = 0; v < 4; v++) begin
      sel_id = VSEL[v];
      put_sync();
      put_frame(VFRAME[v]);
      expect_out(VCNT[v], VEXP[v], VID[v], VTAG[v]);
    end

    // R9: partial frame, then a pause, then an aligned frame
    sel_id = 7'd5;
    put_byte(8'h11); put_byte(8'h22); put_byte(8'h33); put_byte(8'h44); put_byte(8'h55);
    idle_n(6);
    put_frame(FR_A);
    expect_out(14, EX_A, 7'd5, "R9 gap realign");

    // R8: junk, then sync word, then frame, all back to back
    for (int i = 0; i < 7; i++) put_byte(8'h00);
    put_sync();
    put_frame(FR_A);
    expect_out(14, EX_A, 7'd5, "R8 sync realign");

    // R7: unselected source yields nothing
    sel_id = 7'd6;
    put_sync();
    put_frame(FR_A);
    expect_out(0, 112'h0, 7'd5, "R7 mismatch");

    // R2: dropped bytes after reset
    skip_bytes = 8'd3;
    sel_id = 7'd5;
    do_reset();
    @(negedge clk);
    check(active_id == 0, "R1 active_id after second reset", active_id, 0);
    put_byte(8'h5A); put_byte(8'h5A); put_byte(8'h5A);
    put_frame(FR_A);
    expect_out(14, EX_A, 7'd5, "R2 skip");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule